// File: doc/BRIEF.md
# Output Diagnostic and Protection Controller

This block holds the fault bookkeeping and protection state for a six-channel output driver. It takes raw comparator flags from the analog front end and filters each one in time before it counts as a fault. The flags are overcurrent and open-load for each channel, plus a device-wide over-temperature warning and a thermal shutdown. It then sets sticky status bits for the register interface to read, and drives one drive-permit signal for each channel. Filter windows are counted in ticks of an internal prescaler, so they map to microseconds or milliseconds at any system clock.

Overcurrent and thermal shutdown are protective: they force outputs off. Open-load and the temperature warning only report. A channel that trips on overcurrent can be held off until software clears it. It can instead retry by itself after a fixed off time. The retry repeats while the fault persists, and this gives a pulsed soft start for loads with a large inrush current. Thermal shutdown blocks every channel. Its flag can be cleared only once the die is reported cool, below the shutdown point minus hysteresis.

Top module: `outdiag_ctrl`

## Requirements
- R1: After reset all status outputs (`oc_flag`, `ol_flag`, `tw_flag`, `tsd_flag`) are 0 and each `drive_en[i]` equals `on_cmd[i]`.
- R2: `oc_flag[i]` sets and `drive_en[i]` drops only after `oc_raw[i]` has stayed high for FAST_TICKS consecutive ticks while the channel is driven. A low cycle on `oc_raw[i]` restarts the count from zero.
- R3: With `recov_en[i]`=0, a tripped channel stays off with `oc_flag[i]`=1 until a one-cycle `clr_oc[i]` pulse. That pulse clears the flag and permits drive again on the next cycle.
- R4: With `recov_en[i]`=1, a tripped channel is re-permitted after RECOV_TICKS ticks off. If the overcurrent persists, the trip and retry cycle repeats, and `oc_flag[i]` stays 1.
- R5: `ol_flag[i]` sets after `ol_raw[i]` has been high for OL_TICKS ticks, only while `on_cmd[i]`=0 and `led_mode[i]`=0. It never changes any `drive_en`.
- R6: `tw_flag` sets after `tw_raw` has been high for FAST_TICKS ticks and stays latched until `clr_tw`. It never changes any `drive_en`.
- R7: `tsd_flag` sets after `tsd_raw` has been high for FAST_TICKS ticks and is latched. While it is 1, every `drive_en` is 0.
- R8: `clr_tsd` clears `tsd_flag` only while `cool_ok`=1. With `cool_ok`=0 the pulse is ignored and all channels stay off.
- R9: A clear strobe given while the matching filtered condition is still present has no effect, and the flag stays 1.
- R10: A fault on one channel does not change the drive permit or the flags of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_cmd | input | NCH | Per-channel on command |
| recov_en | input | NCH | Per-channel auto-retry enable after overcurrent |
| led_mode | input | NCH | Per-channel LED mode, which suppresses open-load monitoring |
| oc_raw | input | NCH | Raw overcurrent comparator flags |
| ol_raw | input | NCH | Raw open-load comparator flags |
| tw_raw | input | 1 | Raw temperature warning comparator |
| tsd_raw | input | 1 | Raw thermal shutdown comparator |
| cool_ok | input | 1 | Temperature is below shutdown threshold minus hysteresis |
| clr_oc | input | NCH | Overcurrent status clear strobes |
| clr_ol | input | NCH | Open-load status clear strobes |
| clr_tw | input | 1 | Temperature warning clear strobe |
| clr_tsd | input | 1 | Thermal shutdown clear strobe |
| drive_en | output | NCH | Per-channel drive permit |
| oc_flag | output | NCH | Latched overcurrent status |
| ol_flag | output | NCH | Latched open-load status |
| tw_flag | output | 1 | Latched temperature warning |
| tsd_flag | output | 1 | Latched thermal shutdown |

## Verification
The bench sends an overcurrent that drops out for one cycle before every window completes. A filter that failed to restart its count would trip the channel. The bench times the retry loop from drive fall to drive rise and back again. A wrong off-time count, or a missing restart of the filter after resuming, shows up as a duration out of range. Clears are issued while the raw condition is still held, and a thermal clear is tried while the die is not cool. A design that accepted these would drop a flag, or restore drive, when it must not.

// File: rtl/outdiag_pkg.sv
`timescale 1ns/1ps
package outdiag_pkg;
    localparam int unsigned CNT_W = 16;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic oc_flag;
        logic ol_flag;
        logic off;
        cnt_t rcnt;
    } chan_st_t;

    typedef struct packed {
        logic tw;
        logic tsd;
    } therm_st_t;
endpackage

// File: rtl/outdiag_tick.sv
`timescale 1ns/1ps
module outdiag_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == W'(DIV - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/outdiag_filter.sv
`timescale 1ns/1ps
module outdiag_filter
    import outdiag_pkg::*;
#(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic hit
);
    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!raw)                              cnt_d = '0;
        else if (tick && (cnt_q < cnt_t'(LIMIT))) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == cnt_t'(LIMIT));
endmodule

// File: rtl/outdiag_chan.sv
`timescale 1ns/1ps
module outdiag_chan
    import outdiag_pkg::*;
#(
    parameter int unsigned FAST_TICKS  = 32,
    parameter int unsigned OL_TICKS    = 3000,
    parameter int unsigned RECOV_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic on_cmd,
    input  logic recov_en,
    input  logic led_mode,
    input  logic oc_raw,
    input  logic ol_raw,
    input  logic clr_oc,
    input  logic clr_ol,
    input  logic tsd_block,
    output logic drive_en,
    output logic oc_flag,
    output logic ol_flag
);
    chan_st_t st_d, st_q;
    logic oc_hit, ol_hit;
    logic oc_qual, ol_qual;

    assign drive_en = on_cmd & ~st_q.off & ~tsd_block;
    assign oc_qual  = oc_raw & drive_en;
    assign ol_qual  = ol_raw & ~on_cmd & ~led_mode;

    outdiag_filter #(.LIMIT(FAST_TICKS)) u_oc_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(oc_qual), .hit(oc_hit)
    );

    outdiag_filter #(.LIMIT(OL_TICKS)) u_ol_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ol_qual), .hit(ol_hit)
    );

    always_comb begin
        st_d = st_q;
        if (oc_hit) begin
            st_d.oc_flag = 1'b1;
            st_d.off     = 1'b1;
            st_d.rcnt    = '0;
        end else begin
            if (st_q.off && recov_en && tick) begin
                if (st_q.rcnt == cnt_t'(RECOV_TICKS - 1)) begin
                    st_d.off  = 1'b0;
                    st_d.rcnt = '0;
                end else begin
                    st_d.rcnt = st_q.rcnt + 1'b1;
                end
            end
            if (clr_oc) begin
                st_d.oc_flag = 1'b0;
                st_d.off     = 1'b0;
                st_d.rcnt    = '0;
            end
        end
        if (ol_hit)      st_d.ol_flag = 1'b1;
        else if (clr_ol) st_d.ol_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc_flag = st_q.oc_flag;
    assign ol_flag = st_q.ol_flag;
endmodule

// File: rtl/outdiag_ctrl.sv
`timescale 1ns/1ps
module outdiag_ctrl
    import outdiag_pkg::*;
#(
    parameter int unsigned NCH         = 6,
    parameter int unsigned TICK_DIV    = 250,
    parameter int unsigned FAST_TICKS  = 32,
    parameter int unsigned OL_TICKS    = 3000,
    parameter int unsigned RECOV_TICKS = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] on_cmd,
    input  logic [NCH-1:0] recov_en,
    input  logic [NCH-1:0] led_mode,
    input  logic [NCH-1:0] oc_raw,
    input  logic [NCH-1:0] ol_raw,
    input  logic           tw_raw,
    input  logic           tsd_raw,
    input  logic           cool_ok,
    input  logic [NCH-1:0] clr_oc,
    input  logic [NCH-1:0] clr_ol,
    input  logic           clr_tw,
    input  logic           clr_tsd,
    output logic [NCH-1:0] drive_en,
    output logic [NCH-1:0] oc_flag,
    output logic [NCH-1:0] ol_flag,
    output logic           tw_flag,
    output logic           tsd_flag
);
    logic tick;
    logic tw_hit, tsd_hit;
    therm_st_t th_d, th_q;

    outdiag_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    outdiag_filter #(.LIMIT(FAST_TICKS)) u_tw_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(tw_raw), .hit(tw_hit)
    );

    outdiag_filter #(.LIMIT(FAST_TICKS)) u_tsd_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(tsd_raw), .hit(tsd_hit)
    );

    always_comb begin
        th_d = th_q;
        if (tw_hit)      th_d.tw = 1'b1;
        else if (clr_tw) th_d.tw = 1'b0;
        if (tsd_hit)                 th_d.tsd = 1'b1;
        else if (clr_tsd && cool_ok) th_d.tsd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) th_q <= '0;
        else        th_q <= th_d;
    end

    assign tw_flag  = th_q.tw;
    assign tsd_flag = th_q.tsd;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        outdiag_chan #(
            .FAST_TICKS (FAST_TICKS),
            .OL_TICKS   (OL_TICKS),
            .RECOV_TICKS(RECOV_TICKS)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .on_cmd   (on_cmd[i]),
            .recov_en (recov_en[i]),
            .led_mode (led_mode[i]),
            .oc_raw   (oc_raw[i]),
            .ol_raw   (ol_raw[i]),
            .clr_oc   (clr_oc[i]),
            .clr_ol   (clr_ol[i]),
            .tsd_block(th_q.tsd),
            .drive_en (drive_en[i]),
            .oc_flag  (oc_flag[i]),
            .ol_flag  (ol_flag[i])
        );
    end
endmodule

// File: rtl/outdiag_ctrl_chk.sv
`timescale 1ns/1ps
module outdiag_ctrl_chk #(
    parameter int unsigned NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] on_cmd,
    input logic [NCH-1:0] led_mode,
    input logic           cool_ok,
    input logic [NCH-1:0] clr_oc,
    input logic           clr_tw,
    input logic [NCH-1:0] drive_en,
    input logic [NCH-1:0] oc_flag,
    input logic [NCH-1:0] ol_flag,
    input logic           tw_flag,
    input logic           tsd_flag
);
    AST_TSD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_flag |-> (drive_en == '0)); // R7

    AST_TSD_HOLD_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tsd_flag && !cool_ok) |=> tsd_flag); // R8

    AST_TW_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tw_flag) |-> $past(clr_tw)); // R6

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        AST_OC_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(oc_flag[i]) |-> !drive_en[i]); // R2

        AST_OC_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(oc_flag[i]) |-> $past(clr_oc[i])); // R3

        AST_OL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ol_flag[i]) |-> $past(!on_cmd[i] && !led_mode[i])); // R5
    end
endmodule

bind outdiag_ctrl outdiag_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .on_cmd  (on_cmd),
    .led_mode(led_mode),
    .cool_ok (cool_ok),
    .clr_oc  (clr_oc),
    .clr_tw  (clr_tw),
    .drive_en(drive_en),
    .oc_flag (oc_flag),
    .ol_flag (ol_flag),
    .tw_flag (tw_flag),
    .tsd_flag(tsd_flag)
);

// File: tb/outdiag_ctrl_bench.sv
`timescale 1ns/1ps
module outdiag_ctrl_bench;
    localparam int unsigned NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] on_cmd = '0, recov_en = '0, led_mode = '0;
    logic [NCH-1:0] oc_raw = '0, ol_raw = '0, clr_oc = '0, clr_ol = '0;
    logic           tw_raw = 1'b0, tsd_raw = 1'b0, cool_ok = 1'b0;
    logic           clr_tw = 1'b0, clr_tsd = 1'b0;
    logic [NCH-1:0] drive_en, oc_flag, ol_flag;
    logic           tw_flag, tsd_flag;

    always #2 clk = ~clk;

    outdiag_ctrl #(
        .NCH(NCH), .TICK_DIV(4), .FAST_TICKS(4), .OL_TICKS(12), .RECOV_TICKS(6)
    ) u_outdiag_ctrl (
        .clk(clk), .rst_n(rst_n), .on_cmd(on_cmd), .recov_en(recov_en),
        .led_mode(led_mode), .oc_raw(oc_raw), .ol_raw(ol_raw), .tw_raw(tw_raw),
        .tsd_raw(tsd_raw), .cool_ok(cool_ok), .clr_oc(clr_oc), .clr_ol(clr_ol),
        .clr_tw(clr_tw), .clr_tsd(clr_tsd), .drive_en(drive_en),
        .oc_flag(oc_flag), .ol_flag(ol_flag), .tw_flag(tw_flag), .tsd_flag(tsd_flag)
    );

    typedef struct {
        string req;
        int    sig;
        int    ch;
        int    lo;
        int    hi;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_err = 0;
    int meas  = 0;
    bit done  = 1'b0;

    function automatic int observe(int sig, int ch);
        case (sig)
            0:       return int'(drive_en[ch]);
            1:       return int'(oc_flag[ch]);
            2:       return int'(ol_flag[ch]);
            3:       return int'(tw_flag);
            4:       return int'(tsd_flag);
            default: return meas;
        endcase
    endfunction

    // monitor: pops expectations and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it  = q.pop_front();
                act = observe(it.sig, it.ch);
                n_chk++;
                if (act < it.lo || act > it.hi) begin
                    n_err++;
                    $display("FAIL %s sig%0d ch%0d: actual %0d expected %0d..%0d",
                             it.req, it.sig, it.ch, act, it.lo, it.hi);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_rng(string req, int sig, int ch, int lo, int hi);
        item_t it;
        it.req = req; it.sig = sig; it.ch = ch; it.lo = lo; it.hi = hi;
        q.push_back(it);
        @(negedge clk);
        #0.5;
    endtask

    task automatic expect_val(string req, int sig, int ch, int v);
        expect_rng(req, sig, ch, v, v);
    endtask

    task automatic wait_drive(int ch, logic lvl, int maxc);
        int n = 0;
        while (drive_en[ch] !== lvl && n < maxc) begin
            @(negedge clk);
            n++;
        end
        meas = n;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        expect_val("R1", 1, 0, 0);
        expect_val("R1", 2, 4, 0);
        expect_val("R1", 3, 0, 0);
        expect_val("R1", 4, 0, 0);
        expect_val("R1", 0, 0, 0);
        step(1);
        on_cmd = 6'b000111;
        recov_en[1] = 1'b1;
        step(1);
        expect_val("R1", 0, 2, 1);

        // R2: dropouts restart the filter
        for (int k = 0; k < 4; k++) begin
            step(1); oc_raw[0] = 1'b1;
            step(8); oc_raw[0] = 1'b0;
        end
        step(1);
        expect_val("R2", 1, 0, 0);
        expect_val("R2", 0, 0, 1);

        // R2: persistent overcurrent trips channel 0
        step(1); oc_raw[0] = 1'b1;
        step(8);
        expect_val("R2", 0, 0, 1);
        expect_val("R2", 1, 0, 0);
        step(16);
        expect_val("R2", 0, 0, 0);
        expect_val("R2", 1, 0, 1);
        expect_val("R10", 0, 2, 1);
        expect_val("R10", 1, 2, 0);

        // R3: latched off until clear
        step(40);
        expect_val("R3", 0, 0, 0);
        oc_raw[0] = 1'b0;
        step(2);
        expect_val("R3", 0, 0, 0);
        step(1); clr_oc[0] = 1'b1;
        step(1); clr_oc[0] = 1'b0;
        expect_val("R3", 1, 0, 0);
        expect_val("R3", 0, 0, 1);

        // R4: auto-retry on channel 1
        step(1); oc_raw[1] = 1'b1;
        wait_drive(1, 1'b0, 60);
        expect_rng("R2", 5, 0, 13, 19);
        wait_drive(1, 1'b1, 60);
        expect_rng("R4", 5, 0, 20, 26);
        expect_val("R4", 1, 1, 1);
        wait_drive(1, 1'b0, 60);
        expect_rng("R4", 5, 0, 13, 19);
        expect_val("R4", 1, 1, 1);
        step(1); oc_raw[1] = 1'b0;
        wait_drive(1, 1'b1, 60);
        expect_rng("R4", 5, 0, 20, 26);
        step(1); clr_oc[1] = 1'b1;
        step(1); clr_oc[1] = 1'b0;
        expect_val("R4", 1, 1, 0);

        // R5: open-load only while off and not LED mode
        step(1);
        led_mode[5] = 1'b1;
        ol_raw = 6'b110100;
        step(30);
        expect_val("R5", 2, 4, 0);
        step(30);
        expect_val("R5", 2, 4, 1);
        expect_val("R5", 2, 5, 0);
        expect_val("R5", 2, 2, 0);
        expect_val("R5", 0, 2, 1);
        // R9: clear while condition persists
        step(1); clr_ol[4] = 1'b1;
        step(1); clr_ol[4] = 1'b0;
        expect_val("R9", 2, 4, 1);
        step(1); ol_raw = '0;
        step(2); clr_ol[4] = 1'b1;
        step(1); clr_ol[4] = 1'b0;
        expect_val("R5", 2, 4, 0);

        // R6: temperature warning is informational
        step(1); tw_raw = 1'b1;
        step(24);
        expect_val("R6", 3, 0, 1);
        expect_val("R6", 0, 0, 1);
        expect_val("R6", 0, 2, 1);
        step(1); clr_tw = 1'b1;
        step(1); clr_tw = 1'b0;
        expect_val("R9", 3, 0, 1);
        step(1); tw_raw = 1'b0;
        step(2); clr_tw = 1'b1;
        step(1); clr_tw = 1'b0;
        expect_val("R6", 3, 0, 0);

        // R7: thermal shutdown blocks all channels
        step(1); tsd_raw = 1'b1;
        step(24);
        expect_val("R7", 4, 0, 1);
        expect_val("R7", 0, 0, 0);
        expect_val("R7", 0, 2, 0);
        // R9: clear with condition still present while cool_ok is set
        step(1); cool_ok = 1'b1; clr_tsd = 1'b1;
        step(1); clr_tsd = 1'b0;
        expect_val("R9", 4, 0, 1);
        // R8: clear refused while hot
        step(1); tsd_raw = 1'b0; cool_ok = 1'b0;
        step(2); clr_tsd = 1'b1;
        step(1); clr_tsd = 1'b0;
        expect_val("R8", 4, 0, 1);
        expect_val("R8", 0, 2, 0);
        step(1); cool_ok = 1'b1; clr_tsd = 1'b1;
        step(1); clr_tsd = 1'b0;
        expect_val("R8", 4, 0, 0);
        expect_val("R8", 0, 2, 1);
        expect_val("R8", 0, 0, 1);

        step(2);
        done = 1'b1;
        finish_run();
    end
endmodule